// File: doc/BRIEF.md
# Multi-Mode Priority Interrupt Controller

This block gathers interrupt requests from eight active-low external pins, an active-low non-maskable input and a set of internal timer request lines. It reduces them to one pending request: an 8-bit vector and a 5-bit priority. The request goes to the core only when its priority is strictly greater than the current process priority that the core supplies. The core acknowledges the posted request with a single-cycle pulse. The acknowledge clears the request if its source was latched on an edge.

The eight pins work in one of three modes. In dedicated mode each pin is its own source. In expanded mode the eight pins together carry a vector number. In mixed mode the top three pins are dedicated and the low five pins carry the upper bits of a vector. A small write-only register port sets the mode, selects edge or level sensing per pin, and assigns a vector to each dedicated pin and each timer. A source's priority is always bits [7:3] of its vector. Priority 0 never posts.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, req_o is 0. The mode is dedicated, every pin is level-sensed and every programmed vector is 0.
- R2: In dedicated mode, a level-sensed pin that is held low requests its programmed vector. The request appears after the second rising clock edge that follows the pin change, and it clears the same way once the pin returns high.
- R3: In dedicated mode, an edge-sensed pin latches a request on a falling edge. The latch is visible after the third rising edge, stays set after the pin returns high, and clears at the edge where ack_i is high while that pin is the posted source.
- R4: In expanded mode the vector is the bitwise inverse of the eight pins, sensed by level, and edge selections are ignored. A vector below 8 has priority 0 and is not posted.
- R5: In mixed mode, pins 7..5 are dedicated sources. The vector is {inverse of pins 4..0, 3'b010}. Dedicated vectors programmed for pins 4..0 have no effect.
- R6: A falling edge on nmi_ni latches a non-maskable request. It posts with vector 248 and priority 31 no matter what the current priority or the other sources are, and ack_i clears it.
- R7: A maskable request is posted only when its priority is strictly greater than cur_prio_i.
- R8: The highest priority wins. On a tie, dedicated pins win in descending pin order, then timers in ascending index, then the vectored source.
- R9: Timer i requests its programmed vector while tmr_req_i[i] is high. It is not synchronized and ack_i does not clear it.
- R10: Register writes use these addresses: address 0 sets the mode from wdata[1:0] (0 dedicated, 1 expanded, 2 mixed, and a write of 3 is ignored). Address 1 sets the per-pin edge select, where 1 means edge. Addresses 2+i set the vector of pin i. Addresses 10+i set the vector of timer i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 8 | External interrupt pins, active low |
| nmi_ni | input | 1 | Non-maskable input, falling-edge triggered |
| tmr_req_i | input | NUM_TMR | Timer request lines, active high |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| cur_prio_i | input | 5 | Current process priority |
| ack_i | input | 1 | Acknowledge of the posted request |
| req_o | output | 1 | Request posted to the core |
| req_nmi_o | output | 1 | Posted request is the non-maskable one |
| req_vec_o | output | 8 | Vector of the winning request |
| req_prio_o | output | 5 | Priority of the winning request |

## Verification
The bench uses the defaults: SYNC_STAGES=2 and NUM_TMR=2. With two synchronizer stages, the level latency of two edges and the edge latency of three edges can both be checked exactly. With two timers, the bench can test a tie between the timers themselves as well as ties between a timer and a pin and between a timer and the vectored source. Random mode, vector, pin and priority patterns are checked against a bench-side arbitration model. Directed cases cover the acknowledge, NMI pre-emption at priority 31, the vector-below-8 boundary and the ignored mode encoding.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int PIN_W  = 8;
  localparam int VEC_W  = 8;
  localparam int PRIO_W = 5;
  localparam int MIX_DED_W = 3;

  typedef enum logic [1:0] {
    MODE_DED = 2'd0,
    MODE_EXP = 2'd1,
    MODE_MIX = 2'd2
  } pin_mode_e;

  localparam logic [3:0]       ADDR_MODE = 4'd0;
  localparam logic [3:0]       ADDR_EDGE = 4'd1;
  localparam logic [3:0]       ADDR_PIN0 = 4'd2;
  localparam logic [3:0]       ADDR_TMR0 = 4'd10;
  localparam logic [VEC_W-1:0] NMI_VEC   = 8'd248;
  localparam logic [2:0]       MIX_LOW   = 3'b010;
endpackage

// File: rtl/prio_irq_sync.sv
module prio_irq_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_TMR = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [3:0]                       addr_i,
  input  logic [VEC_W-1:0]                 wdata_i,
  output pin_mode_e                        mode_o,
  output logic [PIN_W-1:0]                 edge_o,
  output logic [PIN_W-1:0][VEC_W-1:0]      pin_vec_o,
  output logic [NUM_TMR-1:0][VEC_W-1:0]    tmr_vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_DED;
      edge_o <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_MODE && wdata_i[1:0] != 2'b11) mode_o <= pin_mode_e'(wdata_i[1:0]);
      if (addr_i == ADDR_EDGE) edge_o <= wdata_i;
    end
  end

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_vec_o[p] <= '0;
      else if (we_i && addr_i == ADDR_PIN0 + 4'(p)) pin_vec_o[p] <= wdata_i;
    end
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tmr_vec_o[t] <= '0;
      else if (we_i && addr_i == ADDR_TMR0 + 4'(t)) tmr_vec_o[t] <= wdata_i;
    end
  end
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NUM_TMR = 2,
  parameter int SRC_W   = 4
) (
  input  logic [PIN_W-1:0]              ded_act_i,
  input  logic [PIN_W-1:0][VEC_W-1:0]   pin_vec_i,
  input  logic [NUM_TMR-1:0]            tmr_act_i,
  input  logic [NUM_TMR-1:0][VEC_W-1:0] tmr_vec_i,
  input  logic                          vec_act_i,
  input  logic [VEC_W-1:0]              vec_val_i,
  input  logic                          nmi_act_i,
  input  logic [PRIO_W-1:0]             cur_prio_i,
  output logic                          req_o,
  output logic                          nmi_o,
  output logic [VEC_W-1:0]              vec_o,
  output logic [PRIO_W-1:0]             prio_o,
  output logic [SRC_W-1:0]              src_o
);
  localparam logic [SRC_W-1:0] SRC_VEC  = SRC_W'(PIN_W + NUM_TMR);
  localparam logic [SRC_W-1:0] SRC_NMI  = SRC_W'(PIN_W + NUM_TMR + 1);
  localparam logic [SRC_W-1:0] SRC_NONE = '1;

  logic [PRIO_W-1:0] best_p;
  logic [VEC_W-1:0]  best_v;
  logic [SRC_W-1:0]  best_s;

  // scan from least preferred to most preferred; >= lets later entries win ties
  always_comb begin
    best_p = '0;
    best_v = '0;
    best_s = SRC_NONE;
    if (vec_act_i && vec_val_i[VEC_W-1:3] != '0) begin
      best_p = vec_val_i[VEC_W-1:3];
      best_v = vec_val_i;
      best_s = SRC_VEC;
    end
    for (int t = NUM_TMR-1; t >= 0; t--) begin
      if (tmr_act_i[t] && tmr_vec_i[t][VEC_W-1:3] != '0 && tmr_vec_i[t][VEC_W-1:3] >= best_p) begin
        best_p = tmr_vec_i[t][VEC_W-1:3];
        best_v = tmr_vec_i[t];
        best_s = SRC_W'(PIN_W + t);
      end
    end
    for (int p = 0; p < PIN_W; p++) begin
      if (ded_act_i[p] && pin_vec_i[p][VEC_W-1:3] != '0 && pin_vec_i[p][VEC_W-1:3] >= best_p) begin
        best_p = pin_vec_i[p][VEC_W-1:3];
        best_v = pin_vec_i[p];
        best_s = SRC_W'(p);
      end
    end
  end

  always_comb begin
    if (nmi_act_i) begin
      req_o  = 1'b1;
      nmi_o  = 1'b1;
      vec_o  = NMI_VEC;
      prio_o = '1;
      src_o  = SRC_NMI;
    end else begin
      req_o  = best_p > cur_prio_i;
      nmi_o  = 1'b0;
      vec_o  = best_v;
      prio_o = best_p;
      src_o  = best_s;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_TMR     = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         irq_pin_i,
  input  logic               nmi_ni,
  input  logic [NUM_TMR-1:0] tmr_req_i,
  input  logic               cfg_we_i,
  input  logic [3:0]         cfg_addr_i,
  input  logic [7:0]         cfg_wdata_i,
  input  logic [4:0]         cur_prio_i,
  input  logic               ack_i,
  output logic               req_o,
  output logic               req_nmi_o,
  output logic [7:0]         req_vec_o,
  output logic [4:0]         req_prio_o
);
  localparam int SRC_W = $clog2(PIN_W + NUM_TMR + 3);
  localparam int IN_W  = PIN_W + 1;
  localparam logic [SRC_W-1:0] SRC_NMI = SRC_W'(PIN_W + NUM_TMR + 1);

  pin_mode_e                     mode_q;
  logic [PIN_W-1:0]              edge_sel;
  logic [PIN_W-1:0][VEC_W-1:0]   pin_vec;
  logic [NUM_TMR-1:0][VEC_W-1:0] tmr_vec;

  prio_irq_regs #(.NUM_TMR(NUM_TMR)) i_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .mode_o(mode_q), .edge_o(edge_sel), .pin_vec_o(pin_vec), .tmr_vec_o(tmr_vec)
  );

  logic [IN_W-1:0] sync_q, prev_q, fall;

  prio_irq_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL({IN_W{1'b1}})) i_sync (
    .clk_i, .rst_ni, .d_i({nmi_ni, irq_pin_i}), .q_o(sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= sync_q;
  end

  assign fall = prev_q & ~sync_q;

  logic [PIN_W-1:0] pin_s, ded_mask, edge_keep, lat_q, lat_d, lat_clr, ded_act;
  logic             nmi_q, vec_act, ack_hit;
  logic [VEC_W-1:0] vec_val;
  logic [SRC_W-1:0] post_src;

  assign pin_s = sync_q[PIN_W-1:0];

  always_comb begin
    ded_mask = '0;
    vec_act  = 1'b0;
    vec_val  = '0;
    unique case (mode_q)
      MODE_DED: ded_mask = '1;
      MODE_EXP: begin
        vec_act = 1'b1;
        vec_val = ~pin_s;
      end
      MODE_MIX: begin
        ded_mask = {{MIX_DED_W{1'b1}}, {(PIN_W-MIX_DED_W){1'b0}}};
        vec_act  = 1'b1;
        vec_val  = {~pin_s[PIN_W-MIX_DED_W-1:0], MIX_LOW};
      end
      default: ;
    endcase
  end

  assign edge_keep = ded_mask & edge_sel;
  assign ack_hit   = ack_i & req_o;

  always_comb begin
    for (int p = 0; p < PIN_W; p++) lat_clr[p] = ack_hit && post_src == SRC_W'(p);
  end

  // new falling edge beats a same-cycle acknowledge
  assign lat_d   = ((lat_q & ~lat_clr) | fall[PIN_W-1:0]) & edge_keep;
  assign ded_act = ded_mask & ((edge_sel & lat_q) | (~edge_sel & ~pin_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      nmi_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      nmi_q <= (nmi_q & ~(ack_hit && post_src == SRC_NMI)) | fall[PIN_W];
    end
  end

  prio_irq_arb #(.NUM_TMR(NUM_TMR), .SRC_W(SRC_W)) i_arb (
    .ded_act_i(ded_act), .pin_vec_i(pin_vec),
    .tmr_act_i(tmr_req_i), .tmr_vec_i(tmr_vec),
    .vec_act_i(vec_act), .vec_val_i(vec_val),
    .nmi_act_i(nmi_q), .cur_prio_i(cur_prio_i),
    .req_o(req_o), .nmi_o(req_nmi_o), .vec_o(req_vec_o),
    .prio_o(req_prio_o), .src_o(post_src)
  );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int PIN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_o,
  input logic             req_nmi_o,
  input logic [7:0]       req_vec_o,
  input logic [4:0]       req_prio_o,
  input logic [4:0]       cur_prio_i,
  input logic             nmi_q,
  input logic             nmi_fall,
  input logic [PIN_W-1:0] lat_q,
  input logic [PIN_W-1:0] lat_clr,
  input logic [PIN_W-1:0] edge_keep,
  input logic [1:0]       mode_q
);
  assert_post_above_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !req_nmi_o) |-> (req_prio_o > cur_prio_i));

  assert_no_zero_prio_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (req_prio_o != 5'd0));

  assert_nmi_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_q |-> (req_o && req_nmi_o && req_vec_o == 8'd248));

  assert_nmi_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_q) |-> $past(nmi_fall));

  assert_mode_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b11);

  for (genvar p = 0; p < PIN_W; p++) begin : g_lat
    assert_edge_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lat_q[p] && !lat_clr[p] && edge_keep[p]) |=> (lat_q[p] || !edge_keep[p]));
  end
endmodule

bind prio_irq_ctrl prio_irq_chk #(.PIN_W(8)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_o(req_o), .req_nmi_o(req_nmi_o), .req_vec_o(req_vec_o), .req_prio_o(req_prio_o),
  .cur_prio_i(cur_prio_i), .nmi_q(nmi_q), .nmi_fall(fall[8]),
  .lat_q(lat_q), .lat_clr(lat_clr), .edge_keep(edge_keep), .mode_q(mode_q)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'hFF;
  logic       nmi_n = 1'b1;
  logic [1:0] tmr = 2'b00;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [4:0] cur = '0;
  logic       ack = 1'b0;
  logic       req, req_nmi;
  logic [7:0] vec;
  logic [4:0] prio;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_pin_vec [8];
  logic [7:0] m_tmr_vec [2];

  always #2 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pins), .nmi_ni(nmi_n), .tmr_req_i(tmr),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cur_prio_i(cur), .ack_i(ack),
    .req_o(req), .req_nmi_o(req_nmi), .req_vec_o(vec), .req_prio_o(prio)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick(1);
    we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic clear_cfg();
    wr(4'd0, 8'd0);
    wr(4'd1, 8'd0);
    for (int i = 0; i < 8; i++) begin wr(4'(2 + i), 8'd0); m_pin_vec[i] = 8'd0; end
    for (int i = 0; i < 2; i++) begin wr(4'(10 + i), 8'd0); m_tmr_vec[i] = 8'd0; end
  endtask

  // independent model: walk sources from most preferred, strict > keeps the earlier one
  function automatic logic [8:0] model(input logic [1:0] m, input logic [7:0] p,
                                       input logic [1:0] t, input logic [4:0] c);
    logic [7:0] ded;
    logic [4:0] bp;
    logic [7:0] bv;
    logic [7:0] vv;
    bp = 5'd0; bv = 8'd0;
    ded = (m == 2'd0) ? 8'hFF : (m == 2'd2) ? 8'hE0 : 8'h00;
    for (int i = 7; i >= 0; i--)
      if (ded[i] && !p[i] && m_pin_vec[i][7:3] > bp) begin bp = m_pin_vec[i][7:3]; bv = m_pin_vec[i]; end
    for (int i = 0; i < 2; i++)
      if (t[i] && m_tmr_vec[i][7:3] > bp) begin bp = m_tmr_vec[i][7:3]; bv = m_tmr_vec[i]; end
    if (m != 2'd0) begin
      vv = (m == 2'd1) ? ~p : {~p[4:0], 3'b010};
      if (vv[7:3] > bp) begin bp = vv[7:3]; bv = vv; end
    end
    return {bp > c, bv};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [8:0] e;
    void'($urandom(32'd1234));
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk("R1 reset req", req, 0);
    pins = 8'h00; tick(3);
    chk("R1 zero vectors never post", req, 0);
    pins = 8'hFF; tick(3);

    // R2 level pin latency and release
    wr(4'd5, 8'h40);
    pins = 8'hF7; tick(1);
    chk("R2 not before second edge", req, 0);
    tick(1);
    chk("R2 level req", req, 1);
    chk("R2 level vec", vec, 8'h40);
    chk("R2 level prio", prio, 5'd8);
    // R7 strict comparison
    cur = 5'd8; #1;
    chk("R7 equal priority blocked", req, 0);
    cur = 5'd7; #1;
    chk("R7 lower current posts", req, 1);
    cur = 5'd0;
    pins = 8'hFF; tick(2);
    chk("R2 follows pin release", req, 0);

    // R3 edge latch
    wr(4'd1, 8'h08);
    pins = 8'hF7; tick(2);
    chk("R3 edge not before third edge", req, 0);
    tick(1);
    chk("R3 edge latched", req, 1);
    pins = 8'hFF; tick(4);
    chk("R3 held after pin release", req, 1);
    chk("R3 held vec", vec, 8'h40);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R3 cleared by ack", req, 0);
    clear_cfg();

    // R9 timer
    wr(4'd10, 8'h58);
    tmr = 2'b01; tick(1);
    chk("R9 timer req", req, 1);
    chk("R9 timer vec", vec, 8'h58);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R9 ack does not clear timer", req, 1);
    tmr = 2'b00; tick(1);
    chk("R9 timer release", req, 0);

    // R8 ties
    wr(4'd4, 8'h41); wr(4'd8, 8'h46); wr(4'd10, 8'h47); wr(4'd11, 8'h80);
    pins = 8'hBB; tick(3);
    chk("R8 higher pin wins tie", vec, 8'h46);
    tmr = 2'b01; tick(1);
    chk("R8 pin beats timer on tie", vec, 8'h46);
    tmr = 2'b11; tick(1);
    chk("R8 higher priority timer", vec, 8'h80);
    pins = 8'hFF; wr(4'd11, 8'h45); tick(3);
    chk("R8 timer0 beats timer1 on tie", vec, 8'h47);
    tmr = 2'b00;
    clear_cfg();

    // R4 expanded
    wr(4'd2, 8'hF8);
    wr(4'd0, 8'd1); wr(4'd1, 8'hFF);
    pins = 8'h6A; tick(3);
    chk("R4 expanded req", req, 1);
    chk("R4 expanded vec", vec, 8'h95);
    chk("R4 expanded prio", prio, 5'd18);
    wr(4'd0, 8'd3); tick(1);
    chk("R10 mode 3 ignored", vec, 8'h95);
    pins = 8'hFA; tick(3);
    chk("R4 vector below 8 ignored", req, 0);
    pins = 8'hF7; tick(3);
    chk("R4 vector 8 posts", req, 1);
    chk("R4 vector 8 value", vec, 8'h08);
    wr(4'd10, 8'h08); tmr = 2'b01; tick(1);
    chk("R8 timer beats vectored on tie", req, 1);
    tmr = 2'b00;
    clear_cfg();

    // R5 mixed
    wr(4'd2, 8'hF8); wr(4'd9, 8'h20);
    wr(4'd0, 8'd2);
    pins = 8'h7C; tick(3);
    chk("R5 dedicated pin7 wins", vec, 8'h20);
    pins = 8'hFC; tick(3);
    chk("R5 mixed vector", vec, 8'h1A);
    chk("R5 mixed prio", prio, 5'd3);
    clear_cfg();

    // R6 NMI
    wr(4'd5, 8'hF8);
    pins = 8'hF7; cur = 5'd31;
    nmi_n = 1'b0; tick(3);
    chk("R6 nmi posted at cur 31", req, 1);
    chk("R6 nmi flag", req_nmi, 1);
    chk("R6 nmi vec", vec, 8'd248);
    nmi_n = 1'b1; tick(3);
    chk("R6 nmi held", req_nmi, 1);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R6 nmi cleared", req, 0);
    cur = 5'd0; pins = 8'hFF; tick(3);
    clear_cfg();

    // R8 random against model, level sensing only
    for (int it = 0; it < 300; it++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 2));
      wr(4'd0, {6'd0, m});
      for (int i = 0; i < 8; i++) begin
        m_pin_vec[i] = 8'($urandom_range(0, 255));
        wr(4'(2 + i), m_pin_vec[i]);
      end
      for (int i = 0; i < 2; i++) begin
        m_tmr_vec[i] = 8'($urandom_range(0, 255));
        wr(4'(10 + i), m_tmr_vec[i]);
      end
      pins = 8'($urandom);
      tmr  = 2'($urandom);
      cur  = 5'($urandom);
      tick(3);
      e = model(m, pins, tmr, cur);
      chk("R8 random req", req, e[8]);
      if (e[8]) chk("R8 random vec", vec, e[7:0]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule